// File: doc/BRIEF.md
# Prescaled Modulo-255 PWM Generator

This block produces one pulse-width-modulated output bit. A prescale value and a compare value are written over a small register bus. A fixed divide-by-two clock enable feeds the prescaler, and the prescaler advances an 8-bit count that runs from 0 up to 254 and then starts again at 0. The output is high while the count is at or above the compare value. In practice, it rises when the count meets the compare value and falls when the count returns to zero.

A control bit decides whether the output pin carries the waveform or a general-purpose level that comes in on `gpio_out`. The counter runs in both cases, so the block can also serve as an interval timer. Each wrap of the count sets a sticky overflow flag, and the flag drives `irq` when the interrupt mask allows it. A `halt` input stands for the chip's idle and power-down states: while it is high, the count freezes and the pin is held high.

Top module: `pwm255_gen`

## Requirements
- R1: The count steps through 0..254 and returns to 0 after 254, so one waveform period holds 255 count steps.
- R2: The count advances once every 2*(1+P) clock cycles, where P is the prescale register (address 0). The overflow flag therefore sets once every 510*(1+P) cycles.
- R3: With the output enabled and compare value C below 255, the pin is high for (255-C)*2*(1+P) cycles of each period and low for the rest. It goes high at count C and low at count 0. The compare register is at address 1.
- R4: C = 0 gives a pin that stays high. C = 255 gives a pin that stays low.
- R5: A compare write takes effect only at the next wrap of the count. Until then, the old value keeps shaping the waveform.
- R6: The control register is at address 2, and bit 0 is the output enable. While the enable is clear, the pin copies `gpio_out` one clock later, and the count and the overflow flag keep running.
- R7: While `halt` is high, the pin is high from the next clock, the count is frozen, and no overflow occurs. Counting resumes when `halt` falls.
- R8: Each wrap sets the overflow flag. The flag stays set until a control write has bit 2 set. If a wrap and a clear fall in the same cycle, the flag is set.
- R9: `irq` equals the overflow flag ANDed with control bit 1, the interrupt enable.
- R10: A synchronous reset clears prescale, compare, count, enable, interrupt enable and flag. After reset the pin follows `gpio_out` until software sets the enable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 prescale, 1 compare, 2 control |
| reg_wdata | input | 8 | Register write data |
| halt | input | 1 | Idle/power-down: freeze count, drive pin high |
| gpio_out | input | 1 | General-purpose level used while the output is disabled |
| pwm_pin | output | 1 | Registered output pin level |
| irq | output | 1 | Overflow interrupt request |

## Verification
The assertions assume that `halt`, `gpio_out` and the register bus are synchronous to `clk` and change only between rising edges. They also assume that writes to addresses other than 0..2 do nothing. The stimulus drives every input on the falling edge and uses only the three defined addresses. It changes the prescale value and then waits for two wraps before measuring, so the prescaler's divider is settled before any period or duty count is taken.

// File: rtl/pwm255_pkg.sv
package pwm255_pkg;

    localparam int DATA_W = 8;

    typedef enum logic [1:0] {
        ADDR_PRESCALE = 2'd0,
        ADDR_COMPARE  = 2'd1,
        ADDR_CONTROL  = 2'd2
    } reg_sel_e;

    localparam int CTL_ENABLE = 0;
    localparam int CTL_IRQ_EN = 1;
    localparam int CTL_CLEAR  = 2;

    typedef struct packed {
        logic drive_pwm;
        logic irq_en;
    } ctl_t;

    function automatic logic level_for(input logic [DATA_W-1:0] cnt,
                                       input logic [DATA_W-1:0] cmp);
        return (cnt >= cmp);
    endfunction

endpackage

// File: rtl/pwm255_prescale.sv
module pwm255_prescale #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run,
    input  logic [W-1:0] psc,
    output logic         step
);
    logic         phase;
    logic [W-1:0] div_cnt;
    logic         div_done;

    assign div_done = (div_cnt >= psc);
    assign step     = run & phase & div_done;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= 1'b0;
            div_cnt <= '0;
        end else if (run) begin
            phase <= ~phase;
            if (phase) begin
                div_cnt <= div_done ? '0 : div_cnt + 1'b1;
            end
        end
    end

    a_r2_step_gap: assert property (@(posedge clk) disable iff (rst)
        step |=> !step);

    a_r7_no_step_halted: assert property (@(posedge clk) disable iff (rst)
        !run |-> !step);
endmodule

// File: rtl/pwm255_counter.sv
module pwm255_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         step,
    output logic [W-1:0] cnt,
    output logic         wrap
);
    localparam logic [W-1:0] TOP = W'((1 << W) - 2);

    assign wrap = step && (cnt == TOP);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (step) begin
            cnt <= wrap ? '0 : cnt + 1'b1;
        end
    end

    a_r1_cnt_range: assert property (@(posedge clk) disable iff (rst)
        cnt <= TOP);

    a_r1_wrap_zero: assert property (@(posedge clk) disable iff (rst)
        wrap |=> cnt == '0);

    a_r7_hold_no_step: assert property (@(posedge clk) disable iff (rst)
        !step |=> $stable(cnt));
endmodule

// File: rtl/pwm255_gen.sv
module pwm255_gen
    import pwm255_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         reg_wr,
    input  logic [1:0]   reg_addr,
    input  logic [W-1:0] reg_wdata,
    input  logic         halt,
    input  logic         gpio_out,
    output logic         pwm_pin,
    output logic         irq
);
    logic [W-1:0] psc_q;
    logic [W-1:0] cmp_next_q;
    logic [W-1:0] cmp_act_q;
    ctl_t         ctl_q;
    logic         ovf_q;
    logic         step;
    logic         wrap;
    logic [W-1:0] cnt;
    logic         wr_ctl;

    assign wr_ctl = reg_wr && (reg_sel_e'(reg_addr) == ADDR_CONTROL);

    pwm255_prescale #(.W(W)) u_psc (
        .clk  (clk),
        .rst  (rst),
        .run  (!halt),
        .psc  (psc_q),
        .step (step)
    );

    pwm255_counter #(.W(W)) u_cnt (
        .clk  (clk),
        .rst  (rst),
        .step (step),
        .cnt  (cnt),
        .wrap (wrap)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            psc_q      <= '0;
            cmp_next_q <= '0;
            ctl_q      <= '0;
        end else if (reg_wr) begin
            case (reg_sel_e'(reg_addr))
                ADDR_PRESCALE: psc_q      <= reg_wdata;
                ADDR_COMPARE:  cmp_next_q <= reg_wdata;
                ADDR_CONTROL: begin
                    ctl_q.drive_pwm <= reg_wdata[CTL_ENABLE];
                    ctl_q.irq_en    <= reg_wdata[CTL_IRQ_EN];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cmp_act_q <= '0;
        end else if (wrap) begin
            cmp_act_q <= cmp_next_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ovf_q <= 1'b0;
        end else if (wrap) begin
            ovf_q <= 1'b1;
        end else if (wr_ctl && reg_wdata[CTL_CLEAR]) begin
            ovf_q <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pwm_pin <= 1'b0;
        end else if (halt) begin
            pwm_pin <= 1'b1;
        end else if (ctl_q.drive_pwm) begin
            pwm_pin <= level_for(cnt, cmp_act_q);
        end else begin
            pwm_pin <= gpio_out;
        end
    end

    assign irq = ovf_q & ctl_q.irq_en;

    a_r7_halt_high: assert property (@(posedge clk) disable iff (rst)
        halt |=> pwm_pin);

    a_r6_gpio_follow: assert property (@(posedge clk) disable iff (rst)
        (!ctl_q.drive_pwm && !halt) |=> pwm_pin == $past(gpio_out));

    a_r4_const_low: assert property (@(posedge clk) disable iff (rst)
        (ctl_q.drive_pwm && !halt && cmp_act_q == '1) |=> !pwm_pin);

    a_r4_const_high: assert property (@(posedge clk) disable iff (rst)
        (ctl_q.drive_pwm && cmp_act_q == '0) |=> pwm_pin);

    a_r5_cmp_at_wrap: assert property (@(posedge clk) disable iff (rst)
        !wrap |=> $stable(cmp_act_q));

    a_r8_flag_set: assert property (@(posedge clk) disable iff (rst)
        wrap |=> ovf_q);

    a_r8_flag_sticky: assert property (@(posedge clk) disable iff (rst)
        (ovf_q && !wr_ctl) |=> ovf_q);
endmodule

// File: tb/sim_pwm255_gen.sv
module sim_pwm255_gen;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       reg_wr = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic       halt = 1'b0;
    logic       gpio_out = 1'b0;
    logic       pwm_pin;
    logic       irq;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    logic [7:0] ctl_base = 8'h00;

    // {prescale, compare}
    localparam logic [15:0] VEC [6] = '{
        {8'd0, 8'd0}, {8'd0, 8'd255}, {8'd0, 8'd1},
        {8'd0, 8'd128}, {8'd1, 8'd200}, {8'd2, 8'd254}
    };

    pwm255_gen u0 (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .halt(halt), .gpio_out(gpio_out),
        .pwm_pin(pwm_pin), .irq(irq)
    );

    always #2 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            failures = failures + 1;
            $display("FAIL watchdog actual=%0d expected<150000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic wait_wrap();
        int n;
        wr(2'd2, ctl_base | 8'h04);
        n = 0;
        while (!irq && n < 5000) begin
            @(negedge clk);
            n++;
        end
        if (n >= 5000) chk(1'b0, "R8 wrap timeout", n, 0);
    endtask

    task automatic measure_period(input int psc);
        int n;
        wr(2'd0, psc[7:0]);
        wait_wrap();
        wait_wrap();
        wr(2'd2, ctl_base | 8'h04);
        n = 1;
        while (!irq && n < 5000) begin
            @(negedge clk);
            n++;
        end
        chk(n == 510 * (1 + psc), "R1 R2 wrap interval", n, 510 * (1 + psc));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10: reset state, enable cleared
        chk(pwm_pin == 1'b0, "R10 pin after reset", pwm_pin, 0);
        chk(irq == 1'b0, "R10 irq after reset", irq, 0);
        gpio_out = 1'b1;
        @(negedge clk);
        chk(pwm_pin == 1'b1, "R10 R6 pin follows gpio", pwm_pin, 1);
        gpio_out = 1'b0;
        @(negedge clk);
        chk(pwm_pin == 1'b0, "R6 pin follows gpio low", pwm_pin, 0);

        // R6: counter runs while output disabled
        ctl_base = 8'h02;
        wr(2'd2, 8'h06);
        repeat (600) @(negedge clk);
        chk(irq == 1'b1, "R6 R8 overflow while disabled", irq, 1);

        // R9: mask, R8: sticky flag
        wr(2'd2, 8'h04);
        repeat (600) @(negedge clk);
        chk(irq == 1'b0, "R9 masked irq", irq, 0);
        wr(2'd2, 8'h02);
        chk(irq == 1'b1, "R8 R9 sticky flag unmasked", irq, 1);
        wr(2'd2, 8'h06);
        chk(irq == 1'b0, "R8 flag cleared", irq, 0);

        // R1 R2: wrap period for two prescale values
        measure_period(0);
        measure_period(2);

        // R3 R4: duty vectors
        ctl_base = 8'h03;
        wr(2'd2, ctl_base);
        for (int v = 0; v < 6; v++) begin
            int p;
            int c;
            int per;
            int hi;
            int exp_hi;
            p = int'(VEC[v][15:8]);
            c = int'(VEC[v][7:0]);
            per = 510 * (1 + p);
            exp_hi = (c == 255) ? 0 : (255 - c) * 2 * (1 + p);
            wr(2'd0, p[7:0]);
            wr(2'd1, c[7:0]);
            wait_wrap();
            wait_wrap();
            hi = 0;
            for (int i = 0; i < per; i++) begin
                @(negedge clk);
                if (pwm_pin) hi++;
            end
            chk(hi == exp_hi, "R3 R4 high cycles per period", hi, exp_hi);
        end

        // R5: deferred compare write
        wr(2'd0, 8'd0);
        wr(2'd1, 8'd0);
        wait_wrap();
        wait_wrap();
        wr(2'd1, 8'd255);
        begin
            int lows;
            lows = 0;
            for (int i = 0; i < 400; i++) begin
                @(negedge clk);
                if (!pwm_pin) lows++;
            end
            chk(lows == 0, "R5 old compare kept until wrap", lows, 0);
        end
        wait_wrap();
        repeat (2) @(negedge clk);
        chk(pwm_pin == 1'b0, "R5 new compare after wrap", pwm_pin, 0);

        // R7: halt holds pin high and freezes count
        wr(2'd2, ctl_base | 8'h04);
        halt = 1'b1;
        @(negedge clk);
        chk(pwm_pin == 1'b1, "R7 pin high in halt", pwm_pin, 1);
        begin
            int bad;
            bad = 0;
            for (int i = 0; i < 2000; i++) begin
                @(negedge clk);
                if (!pwm_pin || irq) bad++;
            end
            chk(bad == 0, "R7 frozen during halt", bad, 0);
        end
        halt = 1'b0;
        repeat (600) @(negedge clk);
        chk(irq == 1'b1, "R7 counting resumes", irq, 1);
        chk(pwm_pin == 1'b0, "R7 pwm restored after halt", pwm_pin, 0);

        // R10: reset during operation
        wr(2'd1, 8'd0);
        wait_wrap();
        repeat (2) @(negedge clk);
        chk(pwm_pin == 1'b1, "R4 compare zero high", pwm_pin, 1);
        gpio_out = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(pwm_pin == 1'b0 && irq == 1'b0, "R10 reset mid-run",
            {pwm_pin, irq}, 0);
        @(negedge clk);
        chk(pwm_pin == 1'b0, "R10 enable cleared by reset", pwm_pin, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule